// File: doc/BRIEF.md
# Multi-Mode Expansion I/O Port

This block is an eight-pin bidirectional port that a microcontroller uses to add I/O lines through a small set of memory-mapped registers. The same pins can instead carry outputs and output enables from a programmable logic array, the low byte of the most recently latched MCU address, or the MCU data bus itself when the whole port acts as a peripheral buffer. Each pin is modelled as a separate input level, output value and output enable, so a pad ring or a bench can close the loop.

Software picks the function of each pin with a per-pin select register and a per-pin direction register, and enables the whole-port buffer with one bit of a mode register. The driver enable of a pin in the normal modes is the OR of the array's enable term for that pin and its direction bit. Pins that the parameter `PT_OE_MASK` marks as having no array enable term are steered by the direction bit alone. The address is taken from a multiplexed address/data bus while the address-latch strobe is high.

Top module: `xp_port`

## Requirements
- R1: After reset every register reads 0, every pin enable is 0 and the port is out of peripheral mode.
- R2: Register offsets are select = 0, direction = 1, output data = 2, mode = 4. A write to any of these is read back unchanged on the next cycle. Offsets 5, 6 and 7 read as 0 and writes to them change nothing. Read data is 0 whenever the read strobe is low.
- R3: Outside peripheral mode, a pin's output enable equals its direction bit OR its array enable term.
- R4: A pin whose select bit is 0 and whose direction bit is 1 outputs its output data register bit.
- R5: A pin whose select bit is 0 and whose direction bit is 0 outputs the array data bit, so that an array enable term drives it.
- R6: A pin whose select bit is 1 outputs latched address bit i on pin i (address bits 3..0 on pins 3..0, bits 7..4 on pins 7..4).
- R7: On every clock edge where the address-latch strobe is 1, the address is taken from the multiplexed bus. While the strobe is 0 the address is held, so after the strobe falls it keeps the last value seen while the strobe was high.
- R8: With mode bit 7 set, all pins are enabled and output the MCU write data exactly in cycles where the write strobe is 1 and either peripheral select is 1. Otherwise every pin enable is 0.
- R9: With mode bit 7 set, a read while either peripheral select is 1 returns the pin input levels on the read bus.
- R10: With mode bit 7 set, a write in a cycle where either peripheral select is 1 goes to the pins only and leaves every register unchanged.
- R11: A read at offset 3 returns the current pin input levels. The offset is read-only.
- R12: A pin whose `PT_OE_MASK` bit is 0 ignores its array enable term, and its driver follows the direction bit alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | MCU write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | MCU read data |
| ale | input | 1 | Address-latch strobe |
| ad_bus | input | 8 | Multiplexed address/data bus |
| pt_out | input | 8 | Array output data per pin |
| pt_oe | input | 8 | Array output-enable term per pin |
| psel0 | input | 1 | Peripheral select 0 |
| psel1 | input | 1 | Peripheral select 1 |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
In peripheral mode, a register write and a peripheral bus transfer can happen in the same cycle: the MCU write strobe is high while a peripheral select is active. The bench sets mode bit 7 and then issues writes to register offsets with a select asserted. It requires all pins to carry the write data in that cycle. It then reads the targeted register back with the selects low and requires its old value. Random stimulus keeps the selects, the strobes and the mode bit moving together, so reference-model checks judge many more of these collisions.

// File: rtl/xp_pkg.sv
package xp_pkg;
   localparam int RA_W = 3;
   typedef enum logic [RA_W-1:0] {
      RS_SEL  = 3'd0,
      RS_DIR  = 3'd1,
      RS_DOUT = 3'd2,
      RS_DIN  = 3'd3,
      RS_MODE = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/xp_regs.sv
module xp_regs
   import xp_pkg::*;
#(
   parameter int W     = 8,
   parameter int PBIT  = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RA_W-1:0] addr,
   input  logic [W-1:0]    wdata,
   input  logic            wr,
   input  logic            rd,
   input  logic            periph_hit,
   input  logic [W-1:0]    pin_in,
   output logic [W-1:0]    sel_q,
   output logic [W-1:0]    dir_q,
   output logic [W-1:0]    dout_q,
   output logic [W-1:0]    mode_q,
   output logic [W-1:0]    rdata,
   output logic            periph_en
);
   logic          wr_ok;
   logic [W-1:0]  reg_mux;

   assign wr_ok     = wr && !periph_hit;
   assign periph_en = mode_q[PBIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         dir_q  <= '0;
         dout_q <= '0;
         mode_q <= '0;
      end else if (wr_ok) begin
         case (addr)
            RS_SEL:  sel_q  <= wdata;
            RS_DIR:  dir_q  <= wdata;
            RS_DOUT: dout_q <= wdata;
            RS_MODE: mode_q <= wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         RS_SEL:  reg_mux = sel_q;
         RS_DIR:  reg_mux = dir_q;
         RS_DOUT: reg_mux = dout_q;
         RS_DIN:  reg_mux = pin_in;
         RS_MODE: reg_mux = mode_q;
         default: reg_mux = '0;
      endcase
   end

   always_comb begin
      if (!rd)             rdata = '0;
      else if (periph_hit) rdata = pin_in;
      else                 rdata = reg_mux;
   end

   // R10
   periph_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && periph_hit) |=> ($stable(sel_q) && $stable(dir_q) && $stable(dout_q) && $stable(mode_q)));

   // R2
   sel_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !periph_hit && addr == RS_SEL) |=> (sel_q == $past(wdata)));

   // R2
   unused_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr > RS_MODE) |=> ($stable(sel_q) && $stable(dir_q) && $stable(dout_q) && $stable(mode_q)));
endmodule

// File: rtl/xp_addr_latch.sv
module xp_addr_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ale,
   input  logic [W-1:0] ad_bus,
   output logic [W-1:0] addr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   addr_q <= '0;
      else if (ale) addr_q <= ad_bus;
   end

   // R7
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ale |=> $stable(addr_q));

   // R7
   addr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> (addr_q == $past(ad_bus)));
endmodule

// File: rtl/xp_pin_slice.sv
module xp_pin_slice #(
   parameter bit HAS_PT = 1'b1
) (
   input  logic periph_en,
   input  logic periph_drive,
   input  logic wbit,
   input  logic sel,
   input  logic dir,
   input  logic dout,
   input  logic abit,
   input  logic pt_out,
   input  logic pt_oe,
   output logic out,
   output logic oe
);
   logic pt_en;

   generate
      if (HAS_PT) begin : g_pt
         assign pt_en = pt_oe;
      end else begin : g_nopt
         logic unused_pt;
         assign unused_pt = pt_oe;
         assign pt_en     = 1'b0;
      end
   endgenerate

   always_comb begin
      if (periph_en) begin
         oe  = periph_drive;
         out = wbit;
      end else begin
         oe = pt_en | dir;
         if (sel)      out = abit;
         else if (dir) out = dout;
         else          out = pt_out;
      end
   end

   // R8
   periph_oe_chk: assert final (!(periph_en && !periph_drive) || !oe);
endmodule

// File: rtl/xp_port.sv
module xp_port
   import xp_pkg::*;
#(
   parameter int          PORT_W     = 8,
   parameter int          PERIPH_BIT = 7,
   parameter logic [7:0]  PT_OE_MASK = 8'hF7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [PORT_W-1:0] reg_wdata,
   input  logic              reg_wr,
   input  logic              reg_rd,
   output logic [PORT_W-1:0] reg_rdata,
   input  logic              ale,
   input  logic [PORT_W-1:0] ad_bus,
   input  logic [PORT_W-1:0] pt_out,
   input  logic [PORT_W-1:0] pt_oe,
   input  logic              psel0,
   input  logic              psel1,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_oe
);
   localparam int MASK_W = (PORT_W < 8) ? PORT_W : 8;

   generate
      if (PORT_W < 1 || PORT_W > 8) begin : g_bad_w
         $error("xp_port: PORT_W must lie in 1..8");
      end
      if (PERIPH_BIT >= PORT_W) begin : g_bad_pb
         $error("xp_port: PERIPH_BIT must be below PORT_W");
      end
   endgenerate

   logic [PORT_W-1:0] sel_q, dir_q, dout_q, mode_q, addr_q;
   logic              periph_en, periph_hit, periph_drive;

   assign periph_hit   = periph_en && (psel0 || psel1);
   assign periph_drive = periph_hit && reg_wr;

   xp_regs #(.W(PORT_W), .PBIT(PERIPH_BIT)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .wr         (reg_wr),
      .rd         (reg_rd),
      .periph_hit (periph_hit),
      .pin_in     (pin_in),
      .sel_q      (sel_q),
      .dir_q      (dir_q),
      .dout_q     (dout_q),
      .mode_q     (mode_q),
      .rdata      (reg_rdata),
      .periph_en  (periph_en)
   );

   xp_addr_latch #(.W(PORT_W)) u_alat (
      .clk    (clk),
      .rst_n  (rst_n),
      .ale    (ale),
      .ad_bus (ad_bus),
      .addr_q (addr_q)
   );

   generate
      for (genvar i = 0; i < PORT_W; i++) begin : g_pin
         xp_pin_slice #(.HAS_PT(PT_OE_MASK[i % MASK_W])) u_slice (
            .periph_en    (periph_en),
            .periph_drive (periph_drive),
            .wbit         (reg_wdata[i]),
            .sel          (sel_q[i]),
            .dir          (dir_q[i]),
            .dout         (dout_q[i]),
            .abit         (addr_q[i]),
            .pt_out       (pt_out[i]),
            .pt_oe        (pt_oe[i]),
            .out          (pin_out[i]),
            .oe           (pin_oe[i])
         );
      end
   endgenerate

   // R3
   oe_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !periph_en |-> ((pin_oe & dir_q) == dir_q));

   // R4
   mcu_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !periph_en |-> (((pin_out ^ dout_q) & ~sel_q & dir_q) == '0));

   // R6
   addr_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !periph_en |-> (((pin_out ^ addr_q) & sel_q) == '0));

   // R8
   periph_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_en && !psel0 && !psel1) |-> (pin_oe == '0));
endmodule

// File: tb/xp_port_test.sv
module xp_port_test;
   localparam logic [7:0] MASK = 8'hF7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_rdata;
   logic       ale = 1'b0;
   logic [7:0] ad_bus = '0, pt_out = '0, pt_oe = '0, pin_in = '0;
   logic       psel0 = 1'b0, psel1 = 1'b0;
   logic [7:0] pin_out, pin_oe;

   int n_chk = 0, n_err = 0;
   logic [7:0] m_sel = '0, m_dir = '0, m_dout = '0, m_mode = '0, m_addr = '0;

   always #5 clk = ~clk;

   xp_port #(.PT_OE_MASK(MASK)) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .ale(ale),
      .ad_bus(ad_bus), .pt_out(pt_out), .pt_oe(pt_oe), .psel0(psel0),
      .psel1(psel1), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   function automatic logic hit_f();
      return m_mode[7] && (psel0 || psel1);
   endfunction

   function automatic logic [7:0] exp_oe();
      if (m_mode[7]) return (hit_f() && reg_wr) ? 8'hFF : 8'h00;
      return m_dir | (pt_oe & MASK);
   endfunction

   function automatic logic [7:0] exp_out();
      logic [7:0] r;
      if (m_mode[7]) return reg_wdata;
      for (int i = 0; i < 8; i++)
         r[i] = m_sel[i] ? m_addr[i] : (m_dir[i] ? m_dout[i] : pt_out[i]);
      return r;
   endfunction

   function automatic logic [7:0] exp_rd();
      if (!reg_rd) return 8'h00;
      if (hit_f()) return pin_in;
      case (reg_addr)
         3'd0: return m_sel;
         3'd1: return m_dir;
         3'd2: return m_dout;
         3'd3: return pin_in;
         3'd4: return m_mode;
         default: return 8'h00;
      endcase
   endfunction

   // inputs are set after a falling edge; this compares, updates the model, and advances one cycle
   task automatic step();
      logic [7:0] eo;
      #1;
      eo = exp_oe();
      chk(m_mode[7] ? "R8 oe" : "R3 oe", pin_oe, eo);
      chk(m_mode[7] ? "R8 out" : "R4/R5/R6 out", pin_out & eo, exp_out() & eo);
      chk(hit_f() ? "R9 rd" : (reg_addr == 3'd3 ? "R11 rd" : "R2 rd"), reg_rdata, exp_rd());
      if (reg_wr && !hit_f()) begin
         case (reg_addr)
            3'd0: m_sel  = reg_wdata;
            3'd1: m_dir  = reg_wdata;
            3'd2: m_dout = reg_wdata;
            3'd4: m_mode = reg_wdata;
            default: ;
         endcase
      end
      if (ale) m_addr = ad_bus;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      reg_wr = 0; reg_rd = 0; psel0 = 0; psel1 = 0; ale = 0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      idle(); reg_addr = a; reg_wdata = d; reg_wr = 1; step(); idle();
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      idle(); reg_addr = a; reg_rd = 1; #1; d = reg_rdata; #0; step(); idle();
   endtask

   initial begin
      #2_000_000;
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      #1;
      chk("R1 oe in reset", pin_oe, 8'h00);
      rst_n = 1;
      @(negedge clk);
      // R1: all registers zero after reset
      for (int a = 0; a < 5; a++) begin
         if (a == 3) continue;
         rd(a[2:0], v);
         chk("R1 reset reg", v, 8'h00);
      end
      // R2: map and unused offsets
      wr(3'd0, 8'h00); wr(3'd1, 8'h5A); rd(3'd1, v); chk("R2 dir readback", v, 8'h5A);
      wr(3'd2, 8'hC3); rd(3'd2, v); chk("R2 dout readback", v, 8'hC3);
      wr(3'd6, 8'hFF); rd(3'd6, v); chk("R2 unused reads 0", v, 8'h00);
      rd(3'd1, v); chk("R2 unused write no effect", v, 8'h5A);
      // R11: data in is read-only and tracks pins
      pin_in = 8'h96; wr(3'd3, 8'h11); rd(3'd3, v); chk("R11 din", v, 8'h96);
      // R4: dir=FF, sel=0 -> dout on pins
      wr(3'd1, 8'hFF); #1; chk("R4 pins", pin_out, 8'hC3);
      // R12 / R5: dir=0, all pt enables -> only masked pins driven with pt data
      wr(3'd1, 8'h00); pt_oe = 8'hFF; pt_out = 8'h3C; #1;
      chk("R12 oe mask", pin_oe, MASK);
      chk("R5 pt data", pin_out & MASK, 8'h3C & MASK);
      pt_oe = 8'h00;
      // R7 / R6: latch then hold after strobe falls
      wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
      ale = 1; ad_bus = 8'hA5; step();
      ale = 0; ad_bus = 8'h3C; step(); step();
      chk("R7 held addr on pins", pin_out, 8'hA5);
      chk("R6 addr out enable", pin_oe, 8'hFF);
      // R8 / R10 / R9: peripheral mode collision
      wr(3'd4, 8'h80); #1; chk("R8 quiet", pin_oe, 8'h00);
      idle(); psel0 = 1; reg_addr = 3'd0; reg_wdata = 8'h0F; reg_wr = 1; #1;
      chk("R8 drive oe", pin_oe, 8'hFF); chk("R8 drive data", pin_out, 8'h0F);
      step(); idle();
      rd(3'd0, v); chk("R10 sel unchanged", v, 8'hFF);
      idle(); psel1 = 1; reg_rd = 1; pin_in = 8'h6E; #1;
      chk("R9 periph read", reg_rdata, 8'h6E);
      step(); idle();
      wr(3'd4, 8'h00); rd(3'd4, v); chk("R2 mode cleared", v, 8'h00);
      // random phase
      for (int k = 0; k < 3000; k++) begin
         reg_addr  = $urandom_range(0, 7);
         reg_wdata = $urandom;
         if (reg_addr == 3'd4 && $urandom_range(0, 3) != 0) reg_wdata[7] = 1'b0;
         reg_wr = ($urandom_range(0, 2) == 0);
         reg_rd = $urandom_range(0, 1);
         ale    = $urandom_range(0, 1);
         ad_bus = $urandom; pt_out = $urandom; pt_oe = $urandom; pin_in = $urandom;
         psel0  = ($urandom_range(0, 3) == 0);
         psel1  = ($urandom_range(0, 3) == 0);
         step();
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule